// File: doc/BRIEF.md
# Image Sensor Slave-Mode Sequencer

This block is a host-side controller for an image sensor that runs in slave mode, where the host drives the sensor's exposure and readout pins. When it gets a start command it raises an exposure pulse, which begins pixel integration. After a programmable integration time it raises a frame pulse. The frame pulse ends integration and also opens readout.

It then issues one row-trigger pulse for each active row, followed by extra row triggers that step the sensor through its vertical blanking rows. Four blanking rows is the usual setting. More idle time between frames comes from issuing the next start later, not from more blanking rows. Each trigger reads out exactly one row. The triggers are spaced by a programmable row period so that a row finishes before the next one is requested.

For every active row the block predicts when the sensor's pixels are valid. The prediction window opens a fixed lead after the trigger edge: the horizontal blanking value plus 4 cycles. All configuration is captured when the start is accepted. Each pulse is high for `PULSE_CYC` master clocks (default 2), and all outputs are synchronous to the master clock.

Top module: `sensor_slave_seq`

## Requirements
- R1: A start_i sampled high while idle raises busy_o in the next cycle and raises expose_o two cycles after the sampling edge. Each pulse on expose_o, frame_start_o and row_start_o stays high for exactly PULSE_CYC cycles.
- R2: frame_start_o rises T_eff cycles after expose_o rises, and the two pulses are never high together.
- R3: T_eff equals the programmed integration time, with two exceptions: zero gives the effective row period, and a value from 1 to PULSE_CYC is raised to PULSE_CYC+1.
- R4: The first row_start_o rise comes one effective row period after the frame_start_o rise. Active rows plus blanking rows triggers follow in total, each one effective row period after the previous one.
- R5: A programmed row period below PULSE_CYC+1 is raised to PULSE_CYC+1, so row pulses never merge.
- R6: pix_valid_o rises hblank+4 cycles after each active-row trigger rises and stays high for row_len cycles. Blanking-row triggers open no window.
- R7: done_o is high for one cycle, in the cycle that the last row_start_o of the frame rises.
- R8: busy_o falls one effective row period after the last row_start_o rise. While busy_o is low, no pulse output is high.
- R9: A start_i while busy_o is high is ignored. Configuration inputs changed after a start do not affect the running frame.
- R10: With zero active rows the sequence goes straight from the frame pulse to the blanking triggers. With zero blanking rows done_o marks the last active trigger.
- R11: During reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one frame sequence |
| int_time_i | input | TIME_W | Integration time in clocks |
| act_rows_i | input | ROW_W | Active rows to read |
| blank_rows_i | input | ROW_W | Vertical blanking rows to step through |
| row_period_i | input | PER_W | Clocks between row triggers |
| hblank_i | input | HB_W | Horizontal blanking value |
| row_len_i | input | LEN_W | Valid pixels per row |
| expose_o | output | 1 | Exposure-start pulse to the sensor |
| frame_start_o | output | 1 | Integration-end / readout-enable pulse |
| row_start_o | output | 1 | Row readout trigger pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last row trigger of the frame issued |
| pix_valid_o | output | 1 | Predicted pixel-valid window |

## Verification
The pixel-window assertion assumes that the row period exceeds hblank+4+row_len, so that each window has closed before the next active trigger arrives. Every bench frame is chosen with that margin. The only exception is the clamped-period frame, which has no active rows and therefore opens no windows. The other assertions rely on nothing beyond the clamps the block applies itself, so any start pattern is allowed, including starts during a frame and back-to-back frames.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXPOSE,
    ST_FRAME,
    ST_ROW_ACT,
    ST_ROW_BLK,
    ST_GAP
  } ssq_state_e;

  localparam int unsigned PIX_LEAD = 4;
endpackage

// File: rtl/ssq_pulse.sv
module ssq_pulse #(
  parameter int unsigned WIDTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (fire_i)    cnt_q <= CW'(WIDTH);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  // sequencer spacing must let a pulse finish before the next fire
  p_no_merge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> !pulse_o);
endmodule

// File: rtl/ssq_fsm.sv
module ssq_fsm import ssq_pkg::*; #(
  parameter int unsigned TIME_W    = 16,
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned PER_W     = 12,
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TIME_W-1:0] int_time_i,
  input  logic [ROW_W-1:0]  act_rows_i,
  input  logic [ROW_W-1:0]  blank_rows_i,
  input  logic [PER_W-1:0]  row_period_i,
  output logic              accept_o,
  output logic              fire_exp_o,
  output logic              fire_frm_o,
  output logic              fire_row_o,
  output logic              row_act_o,
  output logic              fire_last_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = ((TIME_W > PER_W) ? TIME_W : PER_W) + 1;
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(PULSE_CYC + 1);

  ssq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q, t_q, per_q;
  logic [ROW_W-1:0] act_q, blk_q, row_q;

  logic [CNT_W-1:0] per_in, t_in, len_cur;
  logic             slot_end, last_act, last_blk, slot_go;

  always_comb begin
    per_in = (CNT_W'(row_period_i) < MIN_LEN) ? MIN_LEN : CNT_W'(row_period_i);
    if (int_time_i == '0)                  t_in = per_in;
    else if (CNT_W'(int_time_i) < MIN_LEN) t_in = MIN_LEN;
    else                                   t_in = CNT_W'(int_time_i);
  end

  assign accept_o = start_i && (st_q == ST_IDLE);
  assign len_cur  = (st_q == ST_EXPOSE) ? t_q : per_q;
  assign slot_end = (cnt_q == len_cur - CNT_W'(1));
  assign last_act = (row_q == act_q - ROW_W'(1));
  assign last_blk = (row_q == blk_q - ROW_W'(1));
  assign slot_go  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      t_q   <= MIN_LEN;
      per_q <= MIN_LEN;
      act_q <= '0;
      blk_q <= '0;
      row_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept_o) begin
          st_q  <= ST_EXPOSE;
          cnt_q <= '0;
          row_q <= '0;
          t_q   <= t_in;
          per_q <= per_in;
          act_q <= act_rows_i;
          blk_q <= blank_rows_i;
        end
        ST_EXPOSE, ST_FRAME, ST_ROW_ACT, ST_ROW_BLK: begin
          cnt_q <= slot_end ? '0 : cnt_q + 1'b1;
          if (slot_end) begin
            case (st_q)
              ST_EXPOSE: st_q <= ST_FRAME;
              ST_FRAME: begin
                if (act_q != '0)      st_q <= ST_ROW_ACT;
                else if (blk_q != '0) st_q <= ST_ROW_BLK;
                else                  st_q <= ST_GAP;
              end
              ST_ROW_ACT: begin
                if (last_act) begin
                  row_q <= '0;
                  st_q  <= (blk_q != '0) ? ST_ROW_BLK : ST_GAP;
                end else begin
                  row_q <= row_q + 1'b1;
                end
              end
              default: begin
                if (last_blk) begin
                  row_q <= '0;
                  st_q  <= ST_GAP;
                end else begin
                  row_q <= row_q + 1'b1;
                end
              end
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign fire_exp_o  = (st_q == ST_EXPOSE) && slot_go;
  assign fire_frm_o  = (st_q == ST_FRAME) && slot_go;
  assign fire_row_o  = ((st_q == ST_ROW_ACT) || (st_q == ST_ROW_BLK)) && slot_go;
  assign row_act_o   = (st_q == ST_ROW_ACT);
  assign fire_last_o = slot_go &&
                       (((st_q == ST_ROW_ACT) && last_act && (blk_q == '0)) ||
                        ((st_q == ST_ROW_BLK) && last_blk));

  p_cfg_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(t_q) && $stable(per_q) && $stable(act_q) && $stable(blk_q)));
  p_int_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EXPOSE) |-> (t_q >= MIN_LEN));
  p_per_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (per_q >= MIN_LEN));
endmodule

// File: rtl/ssq_pix_window.sv
module ssq_pix_window import ssq_pkg::*; #(
  parameter int unsigned HB_W  = 10,
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [HB_W-1:0]  hblank_i,
  input  logic [LEN_W-1:0] row_len_i,
  input  logic             trig_i,
  output logic             pix_o
);
  localparam int unsigned CW = ((HB_W > LEN_W) ? HB_W : LEN_W) + 2;

  logic [HB_W-1:0]  hb_q;
  logic [LEN_W-1:0] len_q;
  logic [CW-1:0]    cnt_q, lead, stop_at;
  logic             run_q;

  assign lead    = CW'(hb_q) + CW'(PIX_LEAD);
  assign stop_at = lead + CW'(len_q);

  // counter reads 0 in the cycle the row pulse rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q  <= '0;
      len_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (accept_i) begin
        hb_q  <= hblank_i;
        len_q <= row_len_i;
      end
      if (trig_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q + CW'(1) >= stop_at) run_q <= 1'b0;
      end
    end
  end

  assign pix_o = run_q && (cnt_q >= lead) && (cnt_q < stop_at);

  p_window_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |-> !pix_o);
endmodule

// File: rtl/sensor_slave_seq.sv
module sensor_slave_seq #(
  parameter int unsigned TIME_W    = 16,
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned PER_W     = 12,
  parameter int unsigned HB_W      = 10,
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TIME_W-1:0] int_time_i,
  input  logic [ROW_W-1:0]  act_rows_i,
  input  logic [ROW_W-1:0]  blank_rows_i,
  input  logic [PER_W-1:0]  row_period_i,
  input  logic [HB_W-1:0]   hblank_i,
  input  logic [LEN_W-1:0]  row_len_i,
  output logic              expose_o,
  output logic              frame_start_o,
  output logic              row_start_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pix_valid_o
);
  localparam int unsigned N_PULSE = 3;

  logic accept, fire_exp, fire_frm, fire_row, row_act, fire_last;
  logic [N_PULSE-1:0] fire_v, pulse_v;
  logic done_q;

  ssq_fsm #(
    .TIME_W(TIME_W), .ROW_W(ROW_W), .PER_W(PER_W), .PULSE_CYC(PULSE_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .int_time_i, .act_rows_i, .blank_rows_i, .row_period_i,
    .accept_o(accept), .fire_exp_o(fire_exp), .fire_frm_o(fire_frm),
    .fire_row_o(fire_row), .row_act_o(row_act), .fire_last_o(fire_last),
    .busy_o(busy_o)
  );

  assign fire_v = {fire_row, fire_frm, fire_exp};

  for (genvar i = 0; i < N_PULSE; i++) begin : g_pulse
    ssq_pulse #(.WIDTH(PULSE_CYC)) u_pulse (
      .clk_i, .rst_ni, .fire_i(fire_v[i]), .pulse_o(pulse_v[i])
    );
  end

  assign expose_o      = pulse_v[0];
  assign frame_start_o = pulse_v[1];
  assign row_start_o   = pulse_v[2];

  ssq_pix_window #(.HB_W(HB_W), .LEN_W(LEN_W)) u_pix (
    .clk_i, .rst_ni, .accept_i(accept), .hblank_i, .row_len_i,
    .trig_i(fire_row && row_act), .pix_o(pix_valid_o)
  );

  // aligned with the rise of the last row pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= fire_last;
  end
  assign done_o = done_q;

  p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(expose_o && frame_start_o));
  p_done_on_row_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(row_start_o));
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(expose_o || frame_start_o || row_start_o));
endmodule

// File: tb/sensor_slave_seq_test.sv
`timescale 1ns/1ps
module sensor_slave_seq_test;
  localparam int P = 2;
  localparam int NK = 9;
  // event kinds
  localparam int K_BUSY_R = 0, K_EXP = 1, K_FRM = 2, K_ROW = 3, K_DONE = 4,
                 K_PIX_R = 5, K_PIX_F = 6, K_BUSY_F = 7, K_EXP_F = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] int_time = '0;
  logic [9:0]  act_rows = '0, blank_rows = '0, hblank = '0;
  logic [11:0] row_period = '0, row_len = '0;
  logic expose, frame_start, row_start, busy, done, pix_valid;

  int cyc = 0;
  int n_tests = 0, n_fail = 0;
  int q[NK][$];
  string tag = "R11";
  string kreq[NK] = '{"R1", "R1", "R2", "R4", "R7", "R6", "R6", "R8", "R1"};

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sensor_slave_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .int_time_i(int_time),
    .act_rows_i(act_rows), .blank_rows_i(blank_rows), .row_period_i(row_period),
    .hblank_i(hblank), .row_len_i(row_len),
    .expose_o(expose), .frame_start_o(frame_start), .row_start_o(row_start),
    .busy_o(busy), .done_o(done), .pix_valid_o(pix_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor: compare each observed edge with the scoreboard
  task automatic obs(input int k, input bit ev);
    if (ev) begin
      if (q[k].size() == 0) chk(0, {kreq[k], "/", tag, " unexpected event"}, cyc, -1);
      else begin
        int e = q[k].pop_front();
        chk(cyc == e, {kreq[k], "/", tag}, cyc, e);
      end
    end
  endtask

  logic pb = 0, pe = 0, pf = 0, pr = 0, pp = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      obs(K_BUSY_R, busy && !pb);
      obs(K_BUSY_F, !busy && pb);
      obs(K_EXP, expose && !pe);
      obs(K_EXP_F, !expose && pe);
      obs(K_FRM, frame_start && !pf);
      obs(K_ROW, row_start && !pr);
      obs(K_DONE, done);
      obs(K_PIX_R, pix_valid && !pp);
      obs(K_PIX_F, !pix_valid && pp);
      if (expose && frame_start) chk(0, "R2 overlap", 1, 0);
    end
    pb = busy; pe = expose; pf = frame_start; pr = row_start; pp = pix_valid;
  end

  // driver: start a frame and push every expected edge
  task automatic run_frame(input int t, input int a, input int b, input int per,
                           input int hb, input int len);
    int s, pe_, te, n, r;
    @(negedge clk);
    int_time = 16'(t); act_rows = 10'(a); blank_rows = 10'(b);
    row_period = 12'(per); hblank = 10'(hb); row_len = 12'(len);
    start = 1'b1;
    s = cyc;
    pe_ = (per < P + 1) ? P + 1 : per;
    te  = (t == 0) ? pe_ : ((t < P + 1) ? P + 1 : t);
    n = a + b;
    q[K_BUSY_R].push_back(s + 1);
    q[K_EXP].push_back(s + 2);
    q[K_EXP_F].push_back(s + 2 + P);
    q[K_FRM].push_back(s + 2 + te);
    for (int j = 0; j < n; j++) begin
      r = s + 2 + te + pe_ * (1 + j);
      q[K_ROW].push_back(r);
      if (j == n - 1) q[K_DONE].push_back(r);
      if (j < a) begin
        q[K_PIX_R].push_back(r + hb + 4);
        if (len > 0) q[K_PIX_F].push_back(r + hb + 4 + len);
      end
    end
    q[K_BUSY_F].push_back(s + 2 + te + pe_ * (1 + n));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected idle");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!expose && !frame_start && !row_start, "R11 pulses", int'(expose | frame_start | row_start), 0);
    chk(!busy && !done, "R11 busy/done", int'(busy | done), 0);
    chk(!pix_valid, "R11 pix", int'(pix_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    tag = "R4 basic";
    run_frame(20, 3, 4, 30, 5, 10);
    wait_idle();

    tag = "R3 zero integration";
    run_frame(0, 2, 1, 25, 3, 8);
    wait_idle();

    tag = "R3/R5 clamps";
    run_frame(1, 0, 2, 2, 0, 0);
    wait_idle();

    tag = "R10 no active rows";
    run_frame(9, 0, 3, 12, 0, 0);
    wait_idle();

    tag = "R10 no blank rows";
    run_frame(15, 2, 0, 20, 2, 6);
    wait_idle();

    tag = "R9 start while busy";
    run_frame(12, 2, 4, 16, 1, 5);
    repeat (10) @(negedge clk);
    int_time = 16'd3; act_rows = 10'd7; blank_rows = 10'd1;
    row_period = 12'd5; hblank = 10'd9; row_len = 12'd40;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R8: start right after busy falls
    tag = "R8 back to back";
    run_frame(7, 1, 1, 14, 0, 3);
    @(negedge clk);
    while (busy) @(negedge clk);
    run_frame(5, 1, 1, 14, 2, 4);
    wait_idle();

    repeat (20) @(negedge clk);
    for (int k = 0; k < NK; k++)
      chk(q[k].size() == 0, {kreq[k], " missing events"}, q[k].size(), 0);
    summary();
  end
endmodule